// File: doc/BRIEF.md
# Priority-Level Interrupt Sampler

This block sits between an interrupt controller and a processor core. The controller presents a 3-bit encoded request level. Code 0 means no request, and codes 1 to 7 are request levels in rising priority. The core presents its status word, which carries a 3-bit interrupt mask, and pulses a strobe at every instruction boundary. At each strobe the block decides whether an interrupt exception is to be taken. If one is, it raises a one-cycle take pulse in the following cycle and reports the accepted level.

Levels 1 to 6 are level-sensitive. Such a level is taken when it is strictly above the mask. The top level, 7, ignores the mask. It is recognised only when the request moves into level 7 from any other value. Such a transition is latched as pending, so it is not lost if the request drops before the next strobe. After a level-7 acceptance, the core's acknowledge releases the tracker for the next level-7 event. Vector lookup, stacking and the mask update after acceptance belong to the core and are not part of this block.

Top module: `irq_level_sampler`

## Requirements
- R1: Request code 0 is never taken. Whenever `take_pulse` is 1, `take_level` is in the range 1 to 7.
- R2: A take happens only at a strobe. `take_pulse` is 1 in cycle t+1 only if `sample_stb` was 1 in cycle t, and the decision uses the inputs of cycle t. Without a strobe, no request is taken.
- R3: Levels 1 to 6 are taken when the level is strictly greater than the mask field `sr_word[10:8]`. A level equal to or below the mask is not taken. The other bits of `sr_word` have no effect.
- R4: A transition of `req_level` into 7 from any other value is taken even when the mask is 7. A transition seen in the same cycle as a strobe, with no earlier level-7 acceptance awaiting acknowledge, is taken at that strobe. After reset the previous level counts as 0.
- R5: A level-7 transition seen without a strobe stays pending. It is taken at the next strobe even if `req_level` has dropped below 7 by then.
- R6: A request held at 7 does not trigger again. It can be taken again only after it has left 7 and returned. A held 7 is never taken through the maskable path.
- R7: When a level-7 event and a maskable level are both eligible at one strobe, the level-7 event wins and `take_level` reads 7. The maskable level is taken at a later strobe if it is still above the mask.
- R8: After a level-7 acceptance, no further level 7 is taken until `core_ack`. A level-7 transition seen in the meantime stays pending and is taken at the first strobe after the ack cycle. A strobe in the ack cycle itself does not take it. An ack while no level-7 acceptance is outstanding has no effect.
- R9: `take_level` reads 0 whenever `take_pulse` is 0. Reset clears outputs and pending state, so a strobe after reset with no request takes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_level | input | 3 | Encoded request level (0 = none, 7 = top, unmaskable) |
| sr_word | input | 16 | Status word; bits 10:8 hold the interrupt mask |
| sample_stb | input | 1 | Instruction-boundary sample strobe |
| core_ack | input | 1 | Core acknowledge of a level-7 acceptance |
| take_pulse | output | 1 | One-cycle pulse: take an interrupt exception |
| take_level | output | 3 | Accepted level while `take_pulse` is 1, else 0 |

## Verification
The bench builds the block with its defaults: a 3-bit level, a 16-bit status word and the mask at bit 8. With these values every level code and every mask value is reachable. The bench fills the status bits outside the mask with random values, so a wrong field position or a leak from those bits shows up at once. Directed sequences drive the level-7 tracker through all of its states, including a transition, an acknowledge and a strobe that coincide in one cycle. A random phase then covers request, mask, strobe and acknowledge combinations against the reference model.

// File: rtl/irq_smp_pkg.sv
package irq_smp_pkg;

    // Tracker for the unmaskable top level.
    typedef enum logic [1:0] {
        TOP_IDLE     = 2'd0,  // nothing latched
        TOP_PEND     = 2'd1,  // edge latched, not yet accepted
        TOP_ACCEPTED = 2'd2,  // accepted, awaiting core acknowledge
        TOP_ACC_PEND = 2'd3   // accepted and a further edge latched
    } top_state_e;

    // Kind of decision made at a sample point.
    typedef struct packed {
        logic fire;     // an exception is to be taken
        logic top;      // the taken level is the unmaskable one
    } take_kind_t;

    // Maskable level wins when it is a real request strictly above the mask.
    function automatic logic beats_mask(input int unsigned lvl,
                                        input int unsigned msk,
                                        input int unsigned top_lvl);
        return (lvl != 0) && (lvl != top_lvl) && (lvl > msk);
    endfunction

    // Level latched while an acceptance is outstanding.
    function automatic logic awaiting_ack(input top_state_e st);
        return (st == TOP_ACCEPTED) || (st == TOP_ACC_PEND);
    endfunction

endpackage

// File: rtl/irq_edge_track.sv
module irq_edge_track #(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] req_level,
    output logic             top_edge
);
    localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

    logic [LVL_W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
        end else begin
            prev_q <= req_level;
        end
    end

    // Entry into the top level from any other code.
    always_comb begin
        top_edge = (req_level == TOP_LVL) && (prev_q != TOP_LVL);
    end

endmodule

// File: rtl/irq_top_tracker.sv
module irq_top_tracker
    import irq_smp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       top_edge,
    input  logic       sample_stb,
    input  logic       core_ack,
    output logic       take_top,
    output top_state_e state_q
);
    top_state_e state_d;
    logic       eligible;

    always_comb begin
        eligible = (state_q == TOP_PEND) || ((state_q == TOP_IDLE) && top_edge);
        take_top = sample_stb && eligible;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TOP_IDLE: begin
                if (take_top)      state_d = TOP_ACCEPTED;
                else if (top_edge) state_d = TOP_PEND;
            end
            TOP_PEND: begin
                if (take_top)      state_d = TOP_ACCEPTED;
            end
            TOP_ACCEPTED: begin
                if (core_ack)      state_d = top_edge ? TOP_PEND : TOP_IDLE;
                else if (top_edge) state_d = TOP_ACC_PEND;
            end
            TOP_ACC_PEND: begin
                if (core_ack)      state_d = TOP_PEND;
            end
            default:               state_d = TOP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TOP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/irq_mask_compare.sv
module irq_mask_compare
    import irq_smp_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic [LVL_W-1:0] req_level,
    input  logic [LVL_W-1:0] mask_lvl,
    output logic             mask_win
);
    localparam int unsigned TOP_LVL = (1 << LVL_W) - 1;

    always_comb begin
        mask_win = beats_mask(int'(req_level), int'(mask_lvl), TOP_LVL);
    end

endmodule

// File: rtl/irq_level_sampler.sv
module irq_level_sampler
    import irq_smp_pkg::*;
#(
    parameter int LVL_W    = 3,
    parameter int SR_W     = 16,
    parameter int MASK_LSB = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] req_level,
    input  logic [SR_W-1:0]  sr_word,
    input  logic             sample_stb,
    input  logic             core_ack,
    output logic             take_pulse,
    output logic [LVL_W-1:0] take_level
);
    localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

    logic             top_edge;
    logic             take_top;
    logic             mask_win;
    logic [LVL_W-1:0] mask_lvl;
    top_state_e       top_state;
    take_kind_t       kind;
    logic [LVL_W-1:0] level_d;

    assign mask_lvl = sr_word[MASK_LSB +: LVL_W];

    irq_edge_track #(.LVL_W(LVL_W)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .req_level (req_level),
        .top_edge  (top_edge)
    );

    irq_top_tracker u_top (
        .clk        (clk),
        .rst        (rst),
        .top_edge   (top_edge),
        .sample_stb (sample_stb),
        .core_ack   (core_ack),
        .take_top   (take_top),
        .state_q    (top_state)
    );

    irq_mask_compare #(.LVL_W(LVL_W)) u_cmp (
        .req_level (req_level),
        .mask_lvl  (mask_lvl),
        .mask_win  (mask_win)
    );

    // Top level outranks any maskable level at the same sample point.
    always_comb begin
        kind.top  = take_top;
        kind.fire = take_top || (sample_stb && mask_win);
        if (kind.top) begin
            level_d = TOP_LVL;
        end else if (kind.fire) begin
            level_d = req_level;
        end else begin
            level_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            take_pulse <= 1'b0;
            take_level <= '0;
        end else begin
            take_pulse <= kind.fire;
            take_level <= level_d;
        end
    end

endmodule

// File: rtl/irq_level_sampler_chk.sv
module irq_level_sampler_chk
    import irq_smp_pkg::*;
#(
    parameter int LVL_W    = 3,
    parameter int SR_W     = 16,
    parameter int MASK_LSB = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [LVL_W-1:0] req_level,
    input logic [SR_W-1:0]  sr_word,
    input logic             sample_stb,
    input logic             core_ack,
    input logic             take_pulse,
    input logic [LVL_W-1:0] take_level,
    input top_state_e       top_state
);
    localparam logic [LVL_W-1:0] TOP_LVL = {LVL_W{1'b1}};

    AST_TAKE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        take_pulse |-> $past(sample_stb)); // R2

    AST_TAKE_LEVEL_NONZERO: assert property (@(posedge clk) disable iff (rst)
        take_pulse |-> (take_level != '0)); // R1

    AST_QUIET_LEVEL_ZERO: assert property (@(posedge clk) disable iff (rst)
        !take_pulse |-> (take_level == '0)); // R9

    AST_MASKABLE_ABOVE_MASK: assert property (@(posedge clk) disable iff (rst)
        (take_pulse && take_level != TOP_LVL) |->
            ((take_level > $past(sr_word[MASK_LSB +: LVL_W])) &&
             (take_level == $past(req_level)))); // R3

    AST_PENDING_HELD: assert property (@(posedge clk) disable iff (rst)
        (top_state == TOP_PEND && !sample_stb) |=> (top_state == TOP_PEND)); // R5

    AST_PENDING_TAKEN_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        (top_state == TOP_PEND && sample_stb) |=>
            (take_pulse && take_level == TOP_LVL)); // R4

    AST_NO_TOP_BEFORE_ACK: assert property (@(posedge clk) disable iff (rst)
        (awaiting_ack(top_state) && !core_ack) |=>
            !(take_pulse && take_level == TOP_LVL)); // R8

endmodule

bind irq_level_sampler irq_level_sampler_chk #(
    .LVL_W    (LVL_W),
    .SR_W     (SR_W),
    .MASK_LSB (MASK_LSB)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_level  (req_level),
    .sr_word    (sr_word),
    .sample_stb (sample_stb),
    .core_ack   (core_ack),
    .take_pulse (take_pulse),
    .take_level (take_level),
    .top_state  (top_state)
);

// File: tb/irq_level_sampler_bench.sv
`timescale 1ns/1ps
module irq_level_sampler_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] req_level = '0;
    logic [15:0] sr_word = '0;
    logic       sample_stb = 1'b0;
    logic       core_ack = 1'b0;
    logic       take_pulse;
    logic [2:0] take_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference model state (behavioural, not the design's structure).
    int m_prev = 0;
    bit m_pend = 1'b0;
    bit m_acc  = 1'b0;
    int exp_p  = 0;
    int exp_l  = 0;

    always #2.5 clk = ~clk;

    irq_level_sampler #(.LVL_W(3), .SR_W(16), .MASK_LSB(8)) u_irq_level_sampler (
        .clk        (clk),
        .rst        (rst),
        .req_level  (req_level),
        .sr_word    (sr_word),
        .sample_stb (sample_stb),
        .core_ack   (core_ack),
        .take_pulse (take_pulse),
        .take_level (take_level)
    );

    task automatic check(input int act_p, input int act_l, input int e_p, input int e_l,
                         input string tag);
        n_checks++;
        if (act_p != e_p || act_l != e_l) begin
            n_fail++;
            $display("FAIL %s: actual pulse=%0d level=%0d expected pulse=%0d level=%0d",
                     tag, act_p, act_l, e_p, e_l);
        end
    endtask

    // One clock: drive, advance the model, then compare after the edge.
    task automatic cyc(input int req, input int msk, input bit stb, input bit ack,
                       input string tag);
        bit e, t7, mk;
        logic [15:0] noise;
        noise = 16'($urandom);
        noise[10:8] = 3'(msk);
        req_level  = 3'(req);
        sr_word    = noise;
        sample_stb = stb;
        core_ack   = ack;
        e  = (req == 7) && (m_prev != 7);
        t7 = stb && !m_acc && (m_pend || e);
        mk = stb && !t7 && (req >= 1) && (req <= 6) && (req > msk);
        exp_p = (t7 || mk) ? 1 : 0;
        exp_l = t7 ? 7 : (mk ? req : 0);
        m_acc  = t7 ? 1'b1 : (ack ? 1'b0 : m_acc);
        m_pend = t7 ? 1'b0 : (m_pend || e);
        m_prev = req;
        @(posedge clk);
        #1;
        check(int'(take_pulse), int'(take_level), exp_p, exp_l, {"model ", tag});
    endtask

    task automatic expect_out(input int e_p, input int e_l, input string tag);
        check(int'(take_pulse), int'(take_level), e_p, e_l, tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_level = '0; sample_stb = 1'b0; core_ack = 1'b0; sr_word = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        m_prev = 0; m_pend = 1'b0; m_acc = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        expect_out(0, 0, "R9 reset state");

        // Maskable levels against the mask field.
        cyc(3, 2, 1, 0, "R3");  expect_out(1, 3, "R3 level 3 over mask 2");
        cyc(3, 3, 1, 0, "R3");  expect_out(0, 0, "R3 level equal to mask");
        cyc(2, 5, 1, 0, "R3");  expect_out(0, 0, "R3 level below mask");
        cyc(6, 5, 1, 0, "R3");  expect_out(1, 6, "R3 level 6 over mask 5");
        cyc(0, 0, 1, 0, "R1");  expect_out(0, 0, "R1 code 0 not taken");
        cyc(4, 0, 0, 0, "R2");  expect_out(0, 0, "R2 no strobe no take");
        cyc(4, 0, 1, 0, "R2");  expect_out(1, 4, "R2 strobe takes");

        // Top level: edge at strobe with mask 7.
        cyc(7, 7, 1, 0, "R4");  expect_out(1, 7, "R4 top taken through mask 7");
        cyc(7, 0, 0, 1, "R8");  expect_out(0, 0, "R8 ack cycle");
        cyc(7, 0, 1, 0, "R6");  expect_out(0, 0, "R6 held top not retaken");
        cyc(5, 7, 0, 0, "R6");
        cyc(7, 7, 0, 0, "R5");  expect_out(0, 0, "R5 edge without strobe");
        cyc(0, 7, 0, 0, "R5");
        cyc(0, 7, 1, 0, "R5");  expect_out(1, 7, "R5 pending taken after drop");
        cyc(0, 7, 0, 1, "R8");

        // Priority of top over maskable.
        cyc(7, 0, 0, 0, "R7");
        cyc(6, 0, 1, 0, "R7");  expect_out(1, 7, "R7 top wins over level 6");
        cyc(6, 0, 1, 0, "R7");  expect_out(1, 6, "R7 level 6 taken next");
        cyc(0, 0, 0, 1, "R8");

        // Second top edge while awaiting acknowledge.
        cyc(7, 0, 1, 0, "R8");  expect_out(1, 7, "R8 first top taken");
        cyc(0, 0, 0, 0, "R8");
        cyc(7, 0, 0, 0, "R8");
        cyc(0, 0, 1, 0, "R8");  expect_out(0, 0, "R8 no top before ack");
        cyc(0, 0, 1, 1, "R8");  expect_out(0, 0, "R8 ack-cycle strobe");
        cyc(0, 0, 1, 0, "R8");  expect_out(1, 7, "R8 pending taken after ack");
        cyc(0, 0, 0, 1, "R8");
        cyc(0, 0, 0, 1, "R8");  expect_out(0, 0, "R8 stray ack");
        cyc(0, 0, 1, 0, "R8");  expect_out(0, 0, "R8 stray ack no effect");

        // Reset clears a pending edge.
        cyc(7, 0, 0, 0, "R9");
        cyc(0, 0, 0, 0, "R9");
        do_reset();
        cyc(0, 0, 1, 0, "R9");  expect_out(0, 0, "R9 reset clears pending");

        // Random mix against the model.
        for (int i = 0; i < 600; i++) begin
            int r;
            r = $urandom_range(0, 9);
            cyc((r > 7) ? 7 : r, $urandom_range(0, 7), 1'($urandom_range(0, 1)),
                ($urandom_range(0, 3) == 0), "R3/R4/R5/R6/R7/R8 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule